// File: doc/BRIEF.md
# Error-Rate Driven Supply Voltage Controller

This block closes a supply voltage loop around a processor that reports timing errors. Each error pulse from the processor adds one to a window counter. A periodic sample strobe reads the counter and clears it, so every sample describes exactly one window. The block subtracts the sampled count from a programmable target count to form a signed differential. The target is given in errors per window, so a target of 0.1% of the window's clock cycles is simply a count. A proportional-integral law then moves a 12-bit code that feeds an external DAC and regulator.

A higher code means a higher supply voltage. A positive differential means there are fewer errors than the target, so the loop lowers the code. A negative differential means there are too many errors, so it raises the code. Both gains are power-of-two shifts, so the block needs no multiplier. The code is clamped to the DAC range. While the code is clamped, the integral stops accumulating.

Top module: `errRatePiCtrl`

## Requirements
- R1: After reset the output code is 4095, which is the highest supply, and the integral term is zero.
- R2: The window count includes every cycle with errPulse high up to and including the strobe cycle. The count is cleared on the strobe, so each sample covers one window only.
- R3: The differential d is refRate minus the sampled count, computed as a signed value. A positive d moves the code down and a negative d moves it up.
- R4: The code changes only on the clock edge one cycle after the strobe edge, and it holds at every other edge.
- R5: On an update, I' = I + (d >>> kiShift) and raw = 4095 - ((d >>> kpShift) + I'). Both shifts are arithmetic, so they round toward minus infinity.
- R6: If raw is above 4095 the code becomes 4095. If raw is below 0 the code becomes 0. Otherwise the code becomes raw.
- R7: When raw is clamped, the integral keeps its old value. It takes I' only when raw lies in 0..4095.
- R8: The window counter saturates at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| errPulse | input | 1 | One error per cycle while high |
| sampleStrobe | input | 1 | One-cycle request to sample and clear the window |
| refRate | input | CNT_W | Target number of errors per window |
| kpShift | input | SHIFT_W | Proportional gain, as a right-shift amount |
| kiShift | input | SHIFT_W | Integral gain, as a right-shift amount |
| vCode | output | CODE_W | Code sent to the DAC; a higher code gives a higher supply |

## Verification
The hardest case to reach from the ports is integral hold during saturation. The integral cannot be seen directly, and it only shows once the loop leaves the clamp. The stimulus first drives several windows with no errors against a large target. This walks the code down to 0 and keeps it there for a few further windows. Then it feeds windows whose count equals the target, so that the code returned to shows whether the integral kept growing while clamped. Counter saturation is reached by overriding the counter width to 10 bits and sending more pulses than that width can count.

// File: rtl/errRatePkg.sv
package errRatePkg;
  // Strobes passed from the loop sequencer to the datapath
  typedef struct packed {
    logic clearCnt;     // window ends this cycle
    logic latchSample;  // capture the window count
    logic applyUpdate;  // run the PI step and load the code
  } loopStrobes_t;
endpackage

// File: rtl/errRateCtrl.sv
module errRateCtrl
  import errRatePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleStrobe,
  output loopStrobes_t strb
);
  logic updatePendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) updatePendQ <= 1'b0;
    else       updatePendQ <= sampleStrobe;
  end

  always_comb begin
    strb.clearCnt    = sampleStrobe;
    strb.latchSample = sampleStrobe;
    strb.applyUpdate = updatePendQ;
  end

  // R4: the update step follows each strobe by exactly one cycle
  assert_update_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> strb.applyUpdate);
  assert_no_stray_update_R4: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStrobe |=> !strb.applyUpdate);
endmodule

// File: rtl/errRateDatapath.sv
module errRateDatapath
  import errRatePkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int CODE_W  = 12,
  parameter int SHIFT_W = 4
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               errPulse,
  input  logic [CNT_W-1:0]   refRate,
  input  logic [SHIFT_W-1:0] kpShift,
  input  logic [SHIFT_W-1:0] kiShift,
  input  loopStrobes_t       strb,
  output logic [CODE_W-1:0]  vCode
);
  localparam int D_W   = CNT_W + 1;
  localparam int INT_W = ((CNT_W > CODE_W) ? CNT_W : CODE_W) + 3;
  localparam int SUM_W = INT_W + 2;
  localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};

  logic [CNT_W-1:0]        cntQ, sampleQ, cntPlus;
  logic signed [INT_W-1:0] integQ;
  logic [CODE_W-1:0]       vCodeQ;

  // window counter, saturating
  always_comb begin
    cntPlus = cntQ;
    if (errPulse && (cntQ != CNT_MAX)) cntPlus = cntQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      sampleQ <= '0;
    end else begin
      if (strb.latchSample) sampleQ <= cntPlus;
      cntQ <= strb.clearCnt ? '0 : cntPlus;
    end
  end

  // PI arithmetic
  logic signed [D_W-1:0]   diff, pTerm, iInc;
  logic signed [SUM_W-1:0] pExt, iExt, integExt, integNext, sumPi, raw, codeMaxS;
  logic satHi, satLo;

  always_comb begin
    diff      = $signed({1'b0, refRate}) - $signed({1'b0, sampleQ});
    pTerm     = diff >>> kpShift;
    iInc      = diff >>> kiShift;
    pExt      = {{(SUM_W-D_W){pTerm[D_W-1]}}, pTerm};
    iExt      = {{(SUM_W-D_W){iInc[D_W-1]}}, iInc};
    integExt  = {{(SUM_W-INT_W){integQ[INT_W-1]}}, integQ};
    codeMaxS  = {{(SUM_W-CODE_W){1'b0}}, CODE_TOP};
    integNext = integExt + iExt;
    sumPi     = pExt + integNext;
    raw       = codeMaxS - sumPi;
    satLo     = raw[SUM_W-1];
    satHi     = !raw[SUM_W-1] && (raw > codeMaxS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      integQ <= '0;
      vCodeQ <= CODE_TOP;
    end else if (strb.applyUpdate) begin
      if (satHi)      vCodeQ <= CODE_TOP;
      else if (satLo) vCodeQ <= '0;
      else begin
        vCodeQ <= raw[CODE_W-1:0];
        integQ <= integNext[INT_W-1:0];
      end
    end
  end

  assign vCode = vCodeQ;

  // R2: a fresh window starts at zero, at most one pulse counted by the next edge
  assert_window_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearCnt |=> (cntQ <= CNT_W'(1)));
  // R8: the counter sticks at full scale until cleared
  assert_cnt_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((cntQ == CNT_MAX) && !strb.clearCnt) |=> (cntQ == CNT_MAX));
  // R4: code holds outside update cycles
  assert_code_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.applyUpdate |=> $stable(vCodeQ));
  // R7: no integration while clamped
  assert_integ_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.applyUpdate && (satHi || satLo)) |=> $stable(integQ));
  // R6: underflow lands on the floor code
  assert_floor_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.applyUpdate && satLo) |=> (vCodeQ == '0));
endmodule

// File: rtl/errRatePiCtrl.sv
module errRatePiCtrl
  import errRatePkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int CODE_W  = 12,
  parameter int SHIFT_W = 4
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               errPulse,
  input  logic               sampleStrobe,
  input  logic [CNT_W-1:0]   refRate,
  input  logic [SHIFT_W-1:0] kpShift,
  input  logic [SHIFT_W-1:0] kiShift,
  output logic [CODE_W-1:0]  vCode
);
  loopStrobes_t strb;

  errRateCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .strb(strb)
  );

  errRateDatapath #(.CNT_W(CNT_W), .CODE_W(CODE_W), .SHIFT_W(SHIFT_W)) i_dp (
    .clk(clk), .rstN(rstN), .errPulse(errPulse), .refRate(refRate),
    .kpShift(kpShift), .kiShift(kiShift), .strb(strb), .vCode(vCode)
  );
endmodule

// File: tb/test_errRatePiCtrl.sv
`timescale 1ns/1ps
module test_errRatePiCtrl;
  localparam int CNT_W = 10;
  localparam int NVEC  = 12;
  localparam int VEC_N [NVEC] = '{0, 0, 4, 8, 30, 30, 30, 12, 5, 8, 0, 16};

  logic clk = 0, rstN = 0, errPulse = 0, sampleStrobe = 0;
  logic [CNT_W-1:0] refRate = '0;
  logic [3:0] kpShift = '0, kiShift = '0;
  logic [11:0] vCode;

  int checks = 0, fails = 0;
  int mInteg = 0, mCode = 4095;
  int mRef = 0, mKp = 0, mKi = 0;

  always #2.5 clk = ~clk;

  errRatePiCtrl #(.CNT_W(CNT_W)) i_errRatePiCtrl (
    .clk(clk), .rstN(rstN), .errPulse(errPulse), .sampleStrobe(sampleStrobe),
    .refRate(refRate), .kpShift(kpShift), .kiShift(kiShift), .vCode(vCode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: vCode actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setCfg(input int r, input int kp, input int ki);
    mRef = r; mKp = kp; mKi = ki;
    @(negedge clk);
    refRate = CNT_W'(r); kpShift = 4'(kp); kiShift = 4'(ki);
  endtask

  // model from R3, R5, R6, R7, R8
  function automatic void modelStep(input int n);
    int cnt, d, p, inew, raw;
    cnt  = (n > 1023) ? 1023 : n;
    d    = mRef - cnt;
    p    = d >>> mKp;
    inew = mInteg + (d >>> mKi);
    raw  = 4095 - (p + inew);
    if (raw > 4095)   mCode = 4095;
    else if (raw < 0) mCode = 0;
    else begin mCode = raw; mInteg = inew; end
  endfunction

  task automatic runWindow(input int n, input bit onStrobe, input string req);
    int prev;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); errPulse = 1;
    end
    @(negedge clk); errPulse = 0;
    @(negedge clk);
    @(negedge clk); sampleStrobe = 1; errPulse = onStrobe;
    prev = int'(vCode);
    @(negedge clk); sampleStrobe = 0; errPulse = 0;
    chk("R4 hold at capture edge", int'(vCode), prev);
    modelStep(n + (onStrobe ? 1 : 0));
    @(negedge clk);
    chk(req, int'(vCode), mCode);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    mInteg = 0; mCode = 4095;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset code", int'(vCode), 4095);

    // table walk: R3 and R5 under varied error counts
    setCfg(8, 1, 2);
    for (int v = 0; v < NVEC; v++) runWindow(VEC_N[v], 1'b0, "R5 table window");

    // R2: pulse on the strobe cycle belongs to the ending window
    runWindow(3, 1'b1, "R2 strobe-cycle pulse");
    runWindow(8, 1'b0, "R2 cleared window");

    // R3 direction: zero errors against target lowers code
    doReset();
    setCfg(20, 0, 15);
    runWindow(0, 1'b0, "R3 positive diff lowers");
    chk("R3 below top", (int'(vCode) < 4095) ? 1 : 0, 1);
    runWindow(60, 1'b0, "R3 negative diff raises");

    // R6 and R7: drive to floor, sit there, then return
    doReset();
    setCfg(1000, 4, 0);
    for (int k = 0; k < 7; k++) runWindow(0, 1'b0, "R6 descend to floor");
    chk("R6 floor reached", int'(vCode), 0);
    runWindow(1000, 1'b0, "R7 integral held while clamped");
    chk("R7 exact return code", int'(vCode), 95);

    // R6 top clamp with integral untouched
    doReset();
    setCfg(0, 0, 0);
    runWindow(100, 1'b0, "R6 top clamp");
    setCfg(50, 15, 0);
    runWindow(50, 1'b0, "R7 integral zero after top clamp");

    // R8 counter saturation
    doReset();
    setCfg(1023, 15, 0);
    runWindow(0, 1'b0, "R8 preload integral");
    runWindow(1100, 1'b0, "R8 saturated count");
    chk("R8 saturation code", int'(vCode), 3072);

    // R1 reset mid-run clears integral
    setCfg(1000, 4, 0);
    for (int k = 0; k < 6; k++) runWindow(0, 1'b0, "R6 floor again");
    doReset();
    chk("R1 reset restores top", int'(vCode), 4095);
    runWindow(1000, 1'b0, "R1 integral cleared by reset");
    chk("R1 zero diff after reset", int'(vCode), 4095);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule